// File: doc/BRIEF.md
# Function-Select ALU with Byte-Aware Flag Register

This block is the arithmetic and logic unit of a small microcoded 16-bit datapath. A 4-bit function code plus a mode bit pick one of sixteen logic functions or sixteen arithmetic functions of the left and right operand buses. The encoding is the one used by the classic 4-bit ALU slice, taken active-high with an active-high carry. The carry into bit 0 is gated by a control bit. An optional stage after the core shifts the result right by one place.

Beside the combinational path sits a registered flags unit that holds carry, zero, negative and overflow. On each clock it loads flags computed over the whole word, over the high byte only or over the low byte only, or it keeps its value. The byte modes let 8-bit instruction variants share the same 16-bit datapath. Each flag can be tested set or clear by the sequencer.

Top module: `fsel_alu`

## Requirements
- R1: With logic_mode_i=1 the result is a bitwise function of A and B chosen by func_i: 0 ~A, 1 ~(A|B), 2 ~A&B, 3 zero, 4 ~(A&B), 5 ~B, 6 A^B, 7 A&~B, 8 ~A|B, 9 ~(A^B), 10 B, 11 A&B, 12 all ones, 13 A|~B, 14 A|B, 15 A.
- R2: With logic_mode_i=0 the result is X+Y+cin, where func_i picks (X,Y): 0 (A,0), 1 (A|B,0), 2 (A|~B,0), 3 (all ones,0), 4 (A,A&~B), 5 (A|B,A&~B), 6 (A,~B), 7 (A&~B,all ones), 8 (A,A&B), 9 (A,B), 10 (A|~B,A&B), 11 (A&B,all ones), 12 (A,A), 13 (A|B,A), 14 (A|~B,A), 15 (A,all ones).
- R3: cin is 1 when carry_en_i=1 and 0 otherwise, so func 9 gives A+B+1 with carry enabled and func 6 gives A-B.
- R4: With shift_en_i=1 the result is the unshifted core result moved right by one bit, with bit 15 filled with 0.
- R5: flag_mode_i=00 (word) loads C = carry out of bit 15, Z = all 16 result bits zero, N = result bit 15, V = signed overflow of the 16-bit addition.
- R6: flag_mode_i=10 (low byte) loads Z from result bits 7:0, N = bit 7, C = carry out of bit 7, V = signed overflow at bit 7.
- R7: flag_mode_i=01 (high byte) loads Z from result bits 15:8, N = bit 15, C = carry out of bit 15, V = signed overflow at bit 15.
- R8: flag_mode_i=11 leaves the flags unchanged whatever the other inputs do.
- R9: In logic mode without shift, a flag load clears C and V.
- R10: With shift enabled, a flag load sets C to the lowest unshifted bit of the selected field (bit 0 for word and low byte, bit 8 for high byte) and clears V.
- R11: flags_o is {V,N,Z,C} (bit 3 down to bit 0), is cleared by rst_ni low at once, and changes only on a rising clk_i edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | 16 | Left operand bus |
| b_i | input | 16 | Right operand bus |
| func_i | input | 4 | Function select |
| logic_mode_i | input | 1 | 1 = logic, 0 = arithmetic |
| carry_en_i | input | 1 | Enables carry into bit 0 |
| shift_en_i | input | 1 | Enables one-bit right shift of the result |
| flag_mode_i | input | 2 | 00 word, 01 high byte, 10 low byte, 11 hold |
| result_o | output | 16 | Combinational result |
| flags_o | output | 4 | Latched flags {V,N,Z,C} |

## Verification
The hardest cases to reach are those where the byte flags and the word flags differ. For example, a low-byte carry or overflow with no word carry, or a shifted high byte whose carry comes from bit 8 rather than bit 0. The vector table picks operands so that exactly one byte crosses its boundary, such as 0x00FF+1 and 0x007F+1. It then runs the same arithmetic under each flag mode. Hold mode is checked by loading a known non-zero flag set and then running a different operation with flag loading held.

// File: rtl/fsel_alu_pkg.sv
package fsel_alu_pkg;
  typedef enum logic [1:0] {
    FL_WORD = 2'b00,
    FL_HI   = 2'b01,
    FL_LO   = 2'b10,
    FL_HOLD = 2'b11
  } flag_mode_e;

  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_N = 2;
  localparam int FLAG_V = 3;
  localparam int FLAG_W = 4;
endpackage

// File: rtl/fsel_core.sv
module fsel_core #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   func_i,
  input  logic         logic_mode_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         co_hi_o,
  output logic         co_lo_o,
  output logic         ov_hi_o,
  output logic         ov_lo_o
);
  localparam int H = W / 2;
  localparam logic [W-1:0] ONES = '1;

  logic [W-1:0] logic_r, op_x, op_y;
  logic [W:0]   sum_w;
  logic [H:0]   sum_l;

  always_comb begin
    unique case (func_i)
      4'd0:  logic_r = ~a_i;
      4'd1:  logic_r = ~(a_i | b_i);
      4'd2:  logic_r = ~a_i & b_i;
      4'd3:  logic_r = '0;
      4'd4:  logic_r = ~(a_i & b_i);
      4'd5:  logic_r = ~b_i;
      4'd6:  logic_r = a_i ^ b_i;
      4'd7:  logic_r = a_i & ~b_i;
      4'd8:  logic_r = ~a_i | b_i;
      4'd9:  logic_r = ~(a_i ^ b_i);
      4'd10: logic_r = b_i;
      4'd11: logic_r = a_i & b_i;
      4'd12: logic_r = ONES;
      4'd13: logic_r = a_i | ~b_i;
      4'd14: logic_r = a_i | b_i;
      default: logic_r = a_i;
    endcase
  end

  // arithmetic functions reduce to one adder fed by an operand pair
  always_comb begin
    unique case (func_i)
      4'd0:  begin op_x = a_i;          op_y = '0;          end
      4'd1:  begin op_x = a_i | b_i;    op_y = '0;          end
      4'd2:  begin op_x = a_i | ~b_i;   op_y = '0;          end
      4'd3:  begin op_x = ONES;         op_y = '0;          end
      4'd4:  begin op_x = a_i;          op_y = a_i & ~b_i;  end
      4'd5:  begin op_x = a_i | b_i;    op_y = a_i & ~b_i;  end
      4'd6:  begin op_x = a_i;          op_y = ~b_i;        end
      4'd7:  begin op_x = a_i & ~b_i;   op_y = ONES;        end
      4'd8:  begin op_x = a_i;          op_y = a_i & b_i;   end
      4'd9:  begin op_x = a_i;          op_y = b_i;         end
      4'd10: begin op_x = a_i | ~b_i;   op_y = a_i & b_i;   end
      4'd11: begin op_x = a_i & b_i;    op_y = ONES;        end
      4'd12: begin op_x = a_i;          op_y = a_i;         end
      4'd13: begin op_x = a_i | b_i;    op_y = a_i;         end
      4'd14: begin op_x = a_i | ~b_i;   op_y = a_i;         end
      default: begin op_x = a_i;        op_y = ONES;        end
    endcase
  end

  assign sum_w = {1'b0, op_x} + {1'b0, op_y} + {{W{1'b0}}, cin_i};
  assign sum_l = {1'b0, op_x[H-1:0]} + {1'b0, op_y[H-1:0]} + {{H{1'b0}}, cin_i};

  assign res_o   = logic_mode_i ? logic_r : sum_w[W-1:0];
  assign co_hi_o = !logic_mode_i && sum_w[W];
  assign co_lo_o = !logic_mode_i && sum_l[H];
  assign ov_hi_o = !logic_mode_i && (op_x[W-1] == op_y[W-1]) && (sum_w[W-1] != op_x[W-1]);
  assign ov_lo_o = !logic_mode_i && (op_x[H-1] == op_y[H-1]) && (sum_l[H-1] != op_x[H-1]);
endmodule

// File: rtl/fsel_shr.sv
module fsel_shr #(
  parameter int W = 16
) (
  input  logic [W-1:0] d_i,
  input  logic         en_i,
  output logic [W-1:0] q_o,
  output logic         out_lo_o,
  output logic         out_hi_o
);
  localparam int H = W / 2;

  logic [W-1:0] shifted;

  genvar i;
  generate
    for (i = 0; i < W - 1; i++) begin : g_bit
      assign shifted[i] = d_i[i+1];
    end
  endgenerate
  assign shifted[W-1] = 1'b0;

  assign q_o      = en_i ? shifted : d_i;
  assign out_lo_o = d_i[0];
  assign out_hi_o = d_i[H];
endmodule

// File: rtl/fsel_flags.sv
module fsel_flags
  import fsel_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [W-1:0]      res_i,
  input  logic              shr_i,
  input  logic              shout_lo_i,
  input  logic              shout_hi_i,
  input  logic              co_hi_i,
  input  logic              co_lo_i,
  input  logic              ov_hi_i,
  input  logic              ov_lo_i,
  output logic [FLAG_W-1:0] flags_o
);
  localparam int H = W / 2;

  flag_mode_e   mode;
  logic [FLAG_W-1:0] nxt;
  logic [FLAG_W-1:0] flags_q;

  assign mode = flag_mode_e'(mode_i);

  always_comb begin
    nxt = flags_q;
    unique case (mode)
      FL_WORD: begin
        nxt[FLAG_Z] = (res_i == '0);
        nxt[FLAG_N] = res_i[W-1];
        nxt[FLAG_C] = shr_i ? shout_lo_i : co_hi_i;
        nxt[FLAG_V] = !shr_i && ov_hi_i;
      end
      FL_HI: begin
        nxt[FLAG_Z] = (res_i[W-1:H] == '0);
        nxt[FLAG_N] = res_i[W-1];
        nxt[FLAG_C] = shr_i ? shout_hi_i : co_hi_i;
        nxt[FLAG_V] = !shr_i && ov_hi_i;
      end
      FL_LO: begin
        nxt[FLAG_Z] = (res_i[H-1:0] == '0);
        nxt[FLAG_N] = res_i[H-1];
        nxt[FLAG_C] = shr_i ? shout_lo_i : co_lo_i;
        nxt[FLAG_V] = !shr_i && ov_lo_i;
      end
      default: nxt = flags_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= nxt;
  end

  assign flags_o = flags_q;

  // R8
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b11 |=> $stable(flags_o));

  // R5
  word_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b00 |=> flags_o[FLAG_Z] == ($past(res_i) == '0));

  // R10
  shift_no_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shr_i && mode_i != 2'b11) |=> !flags_o[FLAG_V]);

  // R6
  lo_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b10 |=> flags_o[FLAG_N] == $past(res_i[H-1]));
endmodule

// File: rtl/fsel_alu.sv
module fsel_alu
  import fsel_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  input  logic [3:0]        func_i,
  input  logic              logic_mode_i,
  input  logic              carry_en_i,
  input  logic              shift_en_i,
  input  logic [1:0]        flag_mode_i,
  output logic [W-1:0]      result_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic [W-1:0] core_res;
  logic co_hi, co_lo, ov_hi, ov_lo, sh_lo, sh_hi;

  fsel_core #(.W(W)) u_core (
    .a_i(a_i), .b_i(b_i), .func_i(func_i), .logic_mode_i(logic_mode_i),
    .cin_i(carry_en_i), .res_o(core_res),
    .co_hi_o(co_hi), .co_lo_o(co_lo), .ov_hi_o(ov_hi), .ov_lo_o(ov_lo)
  );

  fsel_shr #(.W(W)) u_shr (
    .d_i(core_res), .en_i(shift_en_i), .q_o(result_o),
    .out_lo_o(sh_lo), .out_hi_o(sh_hi)
  );

  fsel_flags #(.W(W)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(flag_mode_i), .res_i(result_o),
    .shr_i(shift_en_i), .shout_lo_i(sh_lo), .shout_hi_i(sh_hi),
    .co_hi_i(co_hi), .co_lo_i(co_lo), .ov_hi_i(ov_hi), .ov_lo_i(ov_lo),
    .flags_o(flags_o)
  );

  // R9
  logic_clears_cv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (logic_mode_i && !shift_en_i && flag_mode_i != 2'b11)
      |=> !flags_o[FLAG_C] && !flags_o[FLAG_V]);

  // R4
  shift_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_en_i && flag_mode_i == 2'b00) |=> !flags_o[FLAG_N]);
endmodule

// File: tb/tb_fsel_alu.sv
`timescale 1ns/1ps
module tb_fsel_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a, b;
  logic [3:0]  func;
  logic        lmode, cen, shen;
  logic [1:0]  fmode;
  logic [15:0] res;
  logic [3:0]  flags;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  fsel_alu dut (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .func_i(func),
    .logic_mode_i(lmode), .carry_en_i(cen), .shift_en_i(shen),
    .flag_mode_i(fmode), .result_o(res), .flags_o(flags)
  );

  // {func, logic, cin, shift, fmode, a, b, exp_res, exp_flags{V,N,Z,C}}
  localparam int NV = 17;
  localparam logic [60:0] VEC [NV] = '{
    {4'd6,  1'b1,1'b0,1'b0,2'b00,16'hF0F0,16'hFF00,16'h0FF0,4'b0000}, // R1 xor
    {4'd11, 1'b1,1'b0,1'b0,2'b00,16'h1234,16'h0F0F,16'h0204,4'b0000}, // R1 and
    {4'd14, 1'b1,1'b0,1'b0,2'b00,16'h8000,16'h0001,16'h8001,4'b0100}, // R1 or
    {4'd3,  1'b1,1'b0,1'b0,2'b00,16'h5555,16'hAAAA,16'h0000,4'b0010}, // R1 zero
    {4'd9,  1'b0,1'b0,1'b0,2'b00,16'h7FFF,16'h0001,16'h8000,4'b1100}, // R2 R5 ovf
    {4'd9,  1'b0,1'b1,1'b0,2'b00,16'hFFFF,16'h0001,16'h0001,4'b0001}, // R3 R5 carry
    {4'd6,  1'b0,1'b1,1'b0,2'b00,16'h0005,16'h0005,16'h0000,4'b0011}, // R3 sub
    {4'd6,  1'b0,1'b0,1'b0,2'b00,16'h0003,16'h0005,16'hFFFD,4'b0100}, // R2 A-B-1
    {4'd15, 1'b0,1'b0,1'b0,2'b00,16'h0000,16'h0000,16'hFFFF,4'b0100}, // R2 A-1
    {4'd9,  1'b0,1'b0,1'b0,2'b10,16'h00FF,16'h0001,16'h0100,4'b0011}, // R6 lo carry
    {4'd9,  1'b0,1'b0,1'b0,2'b01,16'h7F00,16'h0100,16'h8000,4'b1100}, // R7 hi ovf
    {4'd9,  1'b0,1'b0,1'b0,2'b10,16'h007F,16'h0001,16'h0080,4'b1100}, // R6 lo ovf
    {4'd15, 1'b1,1'b0,1'b1,2'b00,16'h0003,16'h0000,16'h0001,4'b0001}, // R4 R10 word
    {4'd12, 1'b0,1'b0,1'b1,2'b00,16'h8001,16'h0000,16'h0001,4'b0000}, // R4 R10 A+A
    {4'd15, 1'b1,1'b0,1'b1,2'b01,16'h0300,16'h0000,16'h0180,4'b0001}, // R10 hi bit8
    {4'd12, 1'b1,1'b0,1'b0,2'b00,16'h0000,16'h0000,16'hFFFF,4'b0100}, // R1 ones R9
    {4'd0,  1'b0,1'b1,1'b0,2'b00,16'h1234,16'h0000,16'h1235,4'b0000}  // R2 R3 A+1
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [60:0] v);
    {func, lmode, cen, shen, fmode, a, b} = v[60:20];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    func = 4'd0; lmode = 1'b0; cen = 1'b0; shen = 1'b0; fmode = 2'b11;
    a = '0; b = '0;
    repeat (2) @(negedge clk);
    check("R11 reset", {12'd0, flags}, 16'h0000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      #1;
      check($sformatf("R1/R2/R4 result row %0d", i), res, VEC[i][19:4]);
      @(negedge clk);
      check($sformatf("R5-R10 flags row %0d", i), {12'd0, flags}, {12'd0, VEC[i][3:0]});
    end

    // R8: load 0011 then hold while a different op runs
    @(negedge clk);
    drive(VEC[6]);
    @(negedge clk);
    {func, lmode, cen, shen, fmode, a, b} = {4'd9,1'b0,1'b0,1'b0,2'b11,16'h7FFF,16'h0001};
    #1;
    check("R8 result while holding", res, 16'h8000);
    @(negedge clk);
    @(negedge clk);
    check("R8 hold flags", {12'd0, flags}, 16'h0003);

    // R9: carry set, then logic op clears C
    drive(VEC[5]);
    @(negedge clk);
    check("R9 carry preset", {12'd0, flags}, 16'h0001);
    {func, lmode, cen, shen, fmode, a, b} = {4'd10,1'b1,1'b1,1'b0,2'b00,16'h0000,16'h0042};
    @(negedge clk);
    check("R9 logic clears C/V", {12'd0, flags}, 16'h0000);

    // R11: change only between edges, async clear
    drive(VEC[4]);
    #2;
    check("R11 no change before edge", {12'd0, flags}, 16'h0000);
    @(negedge clk);
    check("R11 loaded at edge", {12'd0, flags}, 16'h000C);
    #1 rst_n = 1'b0;
    #1;
    check("R11 async clear", {12'd0, flags}, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule